// File: doc/BRIEF.md
# Packed Saturating Add, Subtract and Clamp Unit

This block is a registered datapath for fixed-point signal processing. It takes two 32-bit operands and handles the word as four signed byte lanes, two signed halfword lanes or one signed word lane. In each lane it adds or subtracts with saturation. A result that leaves the lane's signed range is held at the nearest end of that range and does not wrap. No carry or borrow crosses a lane boundary.

A third operation scales and limits a value. It shifts each lane right arithmetically, then clamps the shifted value to a signed width chosen at run time. In halfword mode the two halves are treated on their own, which gives a dual version of the operation. A bypass operation copies the first operand to the output unchanged.

Results and per-byte saturation flags are registered one clock after a valid input, together with an output-valid strobe. A sticky flag records any saturation since software last cleared it.

Top module: `packed_sat_alu`

## Requirements
- R1: While reset is asserted, and after it is released until the first valid input, `out_valid`, `result`, `lane_sat` and `sat_sticky` are all zero.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. `result` and `lane_sat` keep their values through cycles without `in_valid`.
- R3: With `lane_mode`=00 (byte), `op_code`=00 (add) or 01 (subtract) acts on four independent signed 8-bit lanes. Each lane is clamped to 127 or -128 with no carry or borrow between lanes.
- R4: With `lane_mode`=01 (halfword), add and subtract act on two independent signed 16-bit lanes. Each lane is clamped to 32767 or -32768.
- R5: With `lane_mode`=10 (word), add and subtract act on one signed 32-bit value with saturation. `lane_mode`=11 behaves exactly as word mode.
- R6: `op_code`=10 (clamp) in word mode shifts `op_a` right arithmetically by `op_b[4:0]` and limits the shifted value to a signed width of `sat_width`+1 bits (1 to 32).
- R7: In halfword and byte modes, clamp applies the same shift to each lane separately. The width is `sat_width`+1, capped at the lane width.
- R8: `lane_sat` bit k refers to byte k (bits 8k+7:8k). A halfword lane that saturates sets both of its byte bits. A word-mode saturation sets all four bits.
- R9: `sat_sticky` becomes 1 after any accepted operation with a nonzero flag. `flag_clr` clears the previously held value. A saturation in the same cycle as `flag_clr` still leaves the flag set.
- R10: `op_code`=11 (bypass) returns `op_a` unchanged with all `lane_sat` bits zero, in every lane mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_a | input | 32 | First operand (minuend, or value to clamp) |
| op_b | input | 32 | Second operand; bits 4:0 give the shift for clamp |
| op_code | input | 2 | 00 add, 01 subtract, 10 clamp, 11 bypass |
| lane_mode | input | 2 | 00 byte, 01 halfword, 10/11 word |
| sat_width | input | 5 | Clamp width minus one |
| flag_clr | input | 1 | Clears the sticky saturation flag |
| out_valid | output | 1 | Registered result valid strobe |
| result | output | 32 | Registered result |
| lane_sat | output | 4 | Registered per-byte saturation flags |
| sat_sticky | output | 1 | Sticky saturation flag |

## Verification
The hardest case to reach is a failure of lane isolation. An error there appears only when a lane boundary sees a carry or borrow while its neighbour holds a value near its own limit. To reach it, the byte and halfword sweeps fill each lane with a different transform of the swept value, so every boundary meets many carry patterns at once. Operands at the range ends are swept exhaustively. For the sticky flag, the bench issues a clear alone, a clear together with a saturating operation, and a clear together with a clean operation.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic [1:0] {
    OP_ADD   = 2'b00,
    OP_SUB   = 2'b01,
    OP_CLAMP = 2'b10,
    OP_PASS  = 2'b11
  } sat_op_e;

  typedef enum logic [1:0] {
    LM_BYTE = 2'b00,
    LM_HALF = 2'b01,
    LM_WORD = 2'b10,
    LM_ALT  = 2'b11
  } lane_mode_e;
endpackage

// File: rtl/sat_rst_sync.sv
module sat_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/sat_addsub_lane.sv
module sat_addsub_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] y,
  output logic         ovf
);
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] raw;
  logic         same_sign;
  logic         sign_flip;

  always_comb begin
    raw       = sub ? (a - b) : (a + b);
    same_sign = (a[W-1] == b[W-1]);
    sign_flip = (raw[W-1] != a[W-1]);
    // add overflows on like signs, subtract on unlike signs
    ovf       = sign_flip & (sub ? ~same_sign : same_sign);
    if (ovf) y = a[W-1] ? MINV : MAXV;
    else     y = raw;
  end
endmodule

// File: rtl/sat_clamp_lane.sv
module sat_clamp_lane #(
  parameter int W   = 8,
  parameter int SHW = 5,
  parameter int WW  = 5
) (
  input  logic [W-1:0]   x,
  input  logic [SHW-1:0] sh,
  input  logic [WW-1:0]  wsel,
  output logic [W-1:0]   y,
  output logic           ovf
);
  localparam logic [WW:0] W_L = (WW+1)'(W);

  logic signed [W-1:0] shifted;
  logic [WW:0]         n_full;
  logic [WW:0]         n_eff;
  logic signed [W:0]   ext;
  logic signed [W:0]   lim;
  logic signed [W:0]   maxv;
  logic signed [W:0]   minv;

  always_comb begin
    shifted = $signed(x) >>> sh;
    n_full  = {1'b0, wsel} + 1'b1;
    n_eff   = (n_full > W_L) ? W_L : n_full;
    ext     = {shifted[W-1], shifted};
    lim     = {{W{1'b0}}, 1'b1} << (n_eff - 1'b1);
    maxv    = lim - 1'b1;
    minv    = -lim;
    ovf     = 1'b0;
    y       = shifted;
    if (ext > maxv) begin
      ovf = 1'b1;
      y   = maxv[W-1:0];
    end else if (ext < minv) begin
      ovf = 1'b1;
      y   = minv[W-1:0];
    end
  end
endmodule

// File: rtl/sat_lane_bank.sv
module sat_lane_bank
  import sat_pkg::*;
#(
  parameter int DW  = 32,
  parameter int LW  = 8,
  parameter int SHW = 5,
  parameter int WW  = 5
) (
  input  logic [DW-1:0]      a,
  input  logic [DW-1:0]      b,
  input  sat_op_e            op,
  input  logic [WW-1:0]      wsel,
  output logic [DW-1:0]      y,
  output logic [DW/LW-1:0]   ovf
);
  localparam int NL = DW / LW;

  logic [SHW-1:0] sh;
  logic           is_sub;
  logic           is_clamp;

  assign sh       = b[SHW-1:0];
  assign is_sub   = (op == OP_SUB);
  assign is_clamp = (op == OP_CLAMP);

  for (genvar i = 0; i < NL; i++) begin : g_lane
    logic [LW-1:0] as_y;
    logic          as_ovf;
    logic [LW-1:0] cl_y;
    logic          cl_ovf;

    sat_addsub_lane #(.W(LW)) u_as (
      .a   (a[i*LW +: LW]),
      .b   (b[i*LW +: LW]),
      .sub (is_sub),
      .y   (as_y),
      .ovf (as_ovf)
    );

    sat_clamp_lane #(.W(LW), .SHW(SHW), .WW(WW)) u_cl (
      .x    (a[i*LW +: LW]),
      .sh   (sh),
      .wsel (wsel),
      .y    (cl_y),
      .ovf  (cl_ovf)
    );

    assign y[i*LW +: LW] = is_clamp ? cl_y : as_y;
    assign ovf[i]        = is_clamp ? cl_ovf : as_ovf;
  end
endmodule

// File: rtl/packed_sat_alu.sv
module packed_sat_alu
  import sat_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [DATA_W-1:0]           op_a,
  input  logic [DATA_W-1:0]           op_b,
  input  logic [1:0]                  op_code,
  input  logic [1:0]                  lane_mode,
  input  logic [$clog2(DATA_W)-1:0]   sat_width,
  input  logic                        flag_clr,
  output logic                        out_valid,
  output logic [DATA_W-1:0]           result,
  output logic [DATA_W/8-1:0]         lane_sat,
  output logic                        sat_sticky
);
  localparam int SHW = $clog2(DATA_W);
  localparam int WW  = $clog2(DATA_W);
  localparam int NB  = DATA_W / 8;
  localparam int NH  = DATA_W / 16;
  localparam int BPH = NB / NH;

  sat_op_e    op;
  lane_mode_e mode;
  logic       rst_q_n;

  assign op   = sat_op_e'(op_code);
  assign mode = lane_mode_e'(lane_mode);

  sat_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  logic [DATA_W-1:0] b_y, h_y, w_y;
  logic [NB-1:0]     b_ovf;
  logic [NH-1:0]     h_ovf;
  logic [0:0]        w_ovf;

  sat_lane_bank #(.DW(DATA_W), .LW(8), .SHW(SHW), .WW(WW)) u_byte (
    .a (op_a), .b (op_b), .op (op), .wsel (sat_width), .y (b_y), .ovf (b_ovf)
  );
  sat_lane_bank #(.DW(DATA_W), .LW(16), .SHW(SHW), .WW(WW)) u_half (
    .a (op_a), .b (op_b), .op (op), .wsel (sat_width), .y (h_y), .ovf (h_ovf)
  );
  sat_lane_bank #(.DW(DATA_W), .LW(DATA_W), .SHW(SHW), .WW(WW)) u_word (
    .a (op_a), .b (op_b), .op (op), .wsel (sat_width), .y (w_y), .ovf (w_ovf)
  );

  // flags always reported per byte
  logic [NB-1:0] h_flags;
  for (genvar k = 0; k < NB; k++) begin : g_hflag
    assign h_flags[k] = h_ovf[k / BPH];
  end

  logic [DATA_W-1:0] sel_y;
  logic [NB-1:0]     sel_f;

  always_comb begin
    case (mode)
      LM_BYTE: begin sel_y = b_y; sel_f = b_ovf;          end
      LM_HALF: begin sel_y = h_y; sel_f = h_flags;        end
      default: begin sel_y = w_y; sel_f = {NB{w_ovf[0]}}; end
    endcase
    if (op == OP_PASS) begin
      sel_y = op_a;
      sel_f = '0;
    end
  end

  logic [DATA_W-1:0] res_q, res_d;
  logic [NB-1:0]     flg_q, flg_d;
  logic              vld_q, vld_d;
  logic              st_q, st_d;

  always_comb begin
    res_d = res_q;
    flg_d = flg_q;
    vld_d = in_valid;
    if (in_valid) begin
      res_d = sel_y;
      flg_d = sel_f;
    end
    st_d = (flag_clr ? 1'b0 : st_q) | (in_valid & (|sel_f));
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      res_q <= '0;
      flg_q <= '0;
      vld_q <= 1'b0;
      st_q  <= 1'b0;
    end else begin
      res_q <= res_d;
      flg_q <= flg_d;
      vld_q <= vld_d;
      st_q  <= st_d;
    end
  end

  assign out_valid  = vld_q;
  assign result     = res_q;
  assign lane_sat   = flg_q;
  assign sat_sticky = st_q;
endmodule

// File: rtl/sat_alu_checker.sv
module sat_alu_checker #(
  parameter int DATA_W = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [DATA_W-1:0]     op_a,
  input logic [1:0]            op_code,
  input logic [1:0]            lane_mode,
  input logic                  flag_clr,
  input logic                  out_valid,
  input logic [DATA_W-1:0]     result,
  input logic [DATA_W/8-1:0]   lane_sat,
  input logic                  sat_sticky
);
  localparam int NB = DATA_W / 8;

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(lane_sat))); // R2
  AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_code == 2'b11) |=> (result == $past(op_a) && lane_sat == '0)); // R10
  AST_HALF_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane_mode == 2'b01) |=> (lane_sat[1] == lane_sat[0] && lane_sat[3] == lane_sat[2])); // R8
  AST_WORD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane_mode[1]) |=> (lane_sat == '0 || lane_sat == {NB{1'b1}})); // R8
  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && |lane_sat) |-> sat_sticky); // R9
  AST_STICKY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !in_valid) |=> !sat_sticky); // R9
endmodule

bind packed_sat_alu sat_alu_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .in_valid   (in_valid),
  .op_a       (op_a),
  .op_code    (op_code),
  .lane_mode  (lane_mode),
  .flag_clr   (flag_clr),
  .out_valid  (out_valid),
  .result     (result),
  .lane_sat   (lane_sat),
  .sat_sticky (sat_sticky)
);

// File: tb/packed_sat_alu_test.sv
module packed_sat_alu_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] op_a, op_b;
  logic [1:0]  op_code, lane_mode;
  logic [4:0]  sat_width;
  logic        flag_clr;
  logic        out_valid;
  logic [31:0] result;
  logic [3:0]  lane_sat;
  logic        sat_sticky;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;
  logic exp_sticky = 1'b0;

  always #5 clk = ~clk;

  packed_sat_alu #(.DATA_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .op_code(op_code), .lane_mode(lane_mode), .sat_width(sat_width),
    .flag_clr(flag_clr), .out_valid(out_valid), .result(result),
    .lane_sat(lane_sat), .sat_sticky(sat_sticky)
  );

  // arithmetic reference built from the requirements
  task automatic model(input logic [31:0] a, input logic [31:0] b,
                       input logic [1:0] op, input logic [1:0] mode,
                       input logic [4:0] sw,
                       output logic [31:0] y, output logic [3:0] f);
    int lw;
    int nl;
    longint acc;
    lw  = (mode == 2'b00) ? 8 : (mode == 2'b01) ? 16 : 32;
    nl  = 32 / lw;
    acc = 0;
    f   = 4'b0;
    if (op == 2'b11) begin
      y = a;
      return;
    end
    for (int k = 0; k < nl; k++) begin
      longint mask, av, bv, r, lim;
      int n;
      bit s;
      mask = (longint'(1) << lw) - 1;
      av = (longint'(a) >> (k * lw)) & mask;
      bv = (longint'(b) >> (k * lw)) & mask;
      if (av >= (longint'(1) << (lw - 1))) av = av - (longint'(1) << lw);
      if (bv >= (longint'(1) << (lw - 1))) bv = bv - (longint'(1) << lw);
      n = lw;
      if (op == 2'b00) r = av + bv;
      else if (op == 2'b01) r = av - bv;
      else begin
        r = av >>> int'(b[4:0]);
        n = (int'(sw) + 1 < lw) ? int'(sw) + 1 : lw;
      end
      lim = longint'(1) << (n - 1);
      s = 1'b0;
      if (r > lim - 1) begin r = lim - 1; s = 1'b1; end
      else if (r < -lim) begin r = -lim; s = 1'b1; end
      acc = acc | ((r & mask) << (k * lw));
      for (int j = 0; j < 4; j++)
        if (j / (4 / nl) == k && s) f[j] = 1'b1;
    end
    y = acc[31:0];
  endtask

  task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                        input logic [1:0] op, input logic [1:0] mode,
                        input logic [4:0] sw, input logic clr, input string tag);
    logic [31:0] ey;
    logic [3:0]  ef;
    model(a, b, op, mode, sw, ey, ef);
    exp_sticky = (clr ? 1'b0 : exp_sticky) | (|ef);
    @(negedge clk);
    in_valid = 1'b1; op_a = a; op_b = b; op_code = op;
    lane_mode = mode; sat_width = sw; flag_clr = clr;
    @(posedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b1 || result !== ey || lane_sat !== ef || sat_sticky !== exp_sticky) begin
      errors++;
      $display("FAIL %s a=%h b=%h op=%0d mode=%0d w=%0d: actual y=%h f=%b v=%b st=%b expected y=%h f=%b v=1 st=%b",
               tag, a, b, op, mode, sw, result, lane_sat, out_valid, sat_sticky, ey, ef, exp_sticky);
    end
  endtask

  task automatic idle_check(input int n);
    logic [31:0] ry;
    logic [3:0]  rf;
    ry = result;
    rf = lane_sat;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; flag_clr = 1'b0;
      @(posedge clk);
      #1;
      checks++;
      if (out_valid !== 1'b0 || result !== ry || lane_sat !== rf) begin
        errors++;
        $display("FAIL R2 idle hold: actual v=%b y=%h f=%b expected v=0 y=%h f=%b",
                 out_valid, result, lane_sat, ry, rf);
      end
    end
  endtask

  task automatic print_summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      print_summary();
      $finish;
    end
  end

  logic [31:0] wvals [9] = '{32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0000,
                             32'h0000_0001, 32'hFFFF_FFFF, 32'h1234_5678,
                             32'h8765_4321, 32'h0000_8000, 32'hFFFF_7FFF};

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0; op_code = '0;
    lane_mode = '0; sat_width = '0; flag_clr = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0 || result !== 32'h0 || lane_sat !== 4'h0 || sat_sticky !== 1'b0) begin
      errors++;
      $display("FAIL R1 in reset: actual v=%b y=%h f=%b st=%b expected all zero",
               out_valid, result, lane_sat, sat_sticky);
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0 || result !== 32'h0 || lane_sat !== 4'h0 || sat_sticky !== 1'b0) begin
      errors++;
      $display("FAIL R1 after release: actual v=%b y=%h f=%b st=%b expected all zero",
               out_valid, result, lane_sat, sat_sticky);
    end

    // R3 byte lanes, each lane a different transform of the swept value
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b += 5) begin
        logic [7:0] a8, b8;
        a8 = 8'(a); b8 = 8'(b);
        for (int op = 0; op < 2; op++)
          run_op({a8, a8 ^ 8'hA5, ~a8, 8'(a8 + 8'd77)},
                 {b8, ~b8, 8'(b8 + 8'd128), b8 ^ 8'h5A},
                 2'(op), 2'b00, 5'd0, 1'b0, "R3 byte");
      end
    end

    // R4 halfword lanes
    for (int a = 0; a < 65536; a += 1021) begin
      for (int b = 0; b < 65536; b += 1021) begin
        logic [15:0] a16, b16;
        a16 = 16'(a); b16 = 16'(b);
        for (int op = 0; op < 2; op++)
          run_op({a16, a16 ^ 16'h8001}, {~b16, b16}, 2'(op), 2'b01, 5'd0, 1'b0, "R4 half");
      end
    end

    // R5 word lane and alternate word encoding
    for (int i = 0; i < 9; i++)
      for (int j = 0; j < 9; j++)
        for (int op = 0; op < 2; op++) begin
          run_op(wvals[i], wvals[j], 2'(op), 2'b10, 5'd0, 1'b0, "R5 word");
          run_op(wvals[i], wvals[j], 2'(op), 2'b11, 5'd0, 1'b0, "R5 mode11");
        end

    // R6 word clamp, every width
    for (int w = 0; w < 32; w++)
      for (int sh = 0; sh < 32; sh += 3)
        for (int i = 0; i < 9; i++)
          run_op(wvals[i], 32'(sh), 2'b10, 2'b10, 5'(w), 1'b0, "R6 clamp word");

    // R7 dual halfword and byte clamp, widths above lane size included
    for (int w = 0; w < 32; w++)
      for (int sh = 0; sh < 32; sh += 3)
        for (int i = 0; i < 9; i++) begin
          run_op(wvals[i] ^ 32'h00F0_0F00, 32'(sh), 2'b10, 2'b01, 5'(w), 1'b0, "R7 clamp half");
          run_op(wvals[i] ^ 32'h3C00_00C3, 32'(sh), 2'b10, 2'b00, 5'(w), 1'b0, "R7 clamp byte");
        end

    // R8 flag mapping on single saturating lanes
    run_op(32'h0000_7F00, 32'h0000_0100, 2'b00, 2'b00, 5'd0, 1'b0, "R8 byte1 only");
    run_op(32'h7FFF_0000, 32'h0001_0000, 2'b00, 2'b01, 5'd0, 1'b0, "R8 half1 only");
    run_op(32'h8000_0000, 32'h0000_0001, 2'b01, 2'b10, 5'd0, 1'b0, "R8 word all");

    // R10 bypass in every mode
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 9; i++)
        run_op(wvals[i], wvals[8 - i], 2'b11, 2'(m), 5'd3, 1'b0, "R10 bypass");

    // R2 hold while idle
    run_op(32'h7F7F_7F7F, 32'h0101_0101, 2'b00, 2'b00, 5'd0, 1'b0, "R2 setup");
    idle_check(3);

    // R9 sticky flag sequences
    @(negedge clk);
    in_valid = 1'b0; flag_clr = 1'b1;
    @(posedge clk);
    #1;
    exp_sticky = 1'b0;
    checks++;
    if (sat_sticky !== 1'b0 || out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R9 clear alone: actual st=%b v=%b expected st=0 v=0", sat_sticky, out_valid);
    end
    run_op(32'h0000_0001, 32'h0000_0001, 2'b00, 2'b10, 5'd0, 1'b0, "R9 clean keeps 0");
    run_op(32'h7FFF_FFFF, 32'h0000_0001, 2'b00, 2'b10, 5'd0, 1'b0, "R9 set");
    run_op(32'h0000_0001, 32'h0000_0001, 2'b00, 2'b10, 5'd0, 1'b0, "R9 held");
    run_op(32'h7FFF_FFFF, 32'h0000_0001, 2'b00, 2'b10, 5'd0, 1'b1, "R9 clear with sat");
    run_op(32'h0000_0001, 32'h0000_0001, 2'b00, 2'b10, 5'd0, 1'b1, "R9 clear with clean");
    idle_check(1);

    done = 1;
    print_summary();
    $finish;
  end
endmodule